// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The block gathers level-sensitive interrupt requests from a set of device slots, each slot owning four pins, and folds them onto a small group of shared interrupt lines. A line is high whenever at least one of the sources routed to it is high. Each line is driven by a counter of the sources currently asserted on it, not by a wide OR gate. The block keeps a copy of each source's last accepted level. A counter moves only when a source's live level differs from that copy.

Sources that change in the same cycle are taken one at a time. A fixed-priority picker favours the lowest source index. A one-hot acknowledge vector names the source whose change is absorbed in the current cycle. A source that returns to its accepted level before its turn has nothing left to report, so it is skipped.

Top module: `irq_share_agg`

## Requirements
- R1: Each bit of `irq_out` is 1 exactly when the counter of that line is non-zero. Once all changes are absorbed, this equals the OR of the `pin_level` bits routed to the line.
- R2: Source index s = slot*4 + pin selects bit s of `pin_level` and `pin_ack`. The source is routed to line (slot + pin) mod NOUT; with the default NOUT = 4, that is (slot + pin) mod 4.
- R3: An accepted 0-to-1 change adds one to the routed line's counter, and an accepted 1-to-0 change subtracts one. The counter and `irq_out` take the new value at the clock edge that ends the acceptance cycle.
- R4: At most one change is accepted per clock. The accepted source is the lowest index whose live level differs from its stored level. `pin_ack` is one-hot for that source during that cycle and zero when nothing differs.
- R5: A source whose live level equals its stored level is ignored: no acknowledge and no counter change. This includes a source that toggles back before its turn.
- R6: While reset is active and after it, all counters and stored levels are zero: `irq_out` is 0 and `count_err` is 0. Reset is asynchronous and active-low, and its release is synchronised over two clock edges.
- R7: `count_err` is a sticky flag. It is set if a counter would step above all-ones or below zero, and it stays 0 in any legal operation.
- R8: A line stays asserted while any of its routed sources remains high. It drops only after the last of them has been accepted as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NSLOT*4 | Live request level per source, index slot*4+pin |
| pin_ack | output | NSLOT*4 | One-hot: source whose change is accepted this cycle |
| irq_out | output | NOUT | Shared interrupt lines |
| count_err | output | 1 | Sticky counter wrap flag |

## Verification
The bench targets several corner cases:
- Many sources changing in one step. A wrong picker would acknowledge more than one source, or the wrong one, and the counters would drift from the reference.
- A source that rises and falls back while higher-priority changes hold it off. A design that queued events instead of comparing levels would count a phantom assertion and leave a line stuck high.
- Two sources sharing one line, released one at a time. A design that ORed only the latest event would drop the line early.
- A mid-run reset with lines high. A stale counter would survive the reset.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

  localparam int unsigned PINS_PER_SLOT = 4;

  // Line reached by a source: (slot + pin) modulo the number of lines.
  function automatic int unsigned line_of(input int unsigned src,
                                          input int unsigned nout);
    return ((src / PINS_PER_SLOT) + (src % PINS_PER_SLOT)) % nout;
  endfunction

endpackage

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int unsigned NSRC = 128,
  parameter int unsigned IW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic            take_vld,
  input  logic [IW-1:0]   take_idx,
  output logic [NSRC-1:0] differ
);

  logic [NSRC-1:0] seen_q;
  logic [NSRC-1:0] seen_d;

  always_comb begin
    seen_d = seen_q;
    if (take_vld) seen_d[take_idx] = lvl[take_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (take_vld) seen_q <= seen_d;
  end

  assign differ = lvl ^ seen_q;

  // R5: the stored copy moves to the live level of the accepted source
  p_copy_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |=> seen_q[$past(take_idx)] == $past(lvl[take_idx]));

  // R5: nothing accepted, stored copy untouched
  p_copy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take_vld |=> $stable(seen_q));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 128,
  parameter int unsigned IW = 7
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          vld
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    vld = |req;
    gnt = vld ? (N'(1) << idx) : '0;
  end

endmodule

// File: rtl/irq_line_count.sv
module irq_line_count #(
  parameter int unsigned CW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump_up,
  input  logic bump_dn,
  output logic line_on,
  output logic wrap_err
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          full, empty;

  assign full  = (cnt_q == {CW{1'b1}});
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (bump_up) begin
      if (full) err_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (bump_dn) begin
      if (empty) err_d = 1'b1;
      else       cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (bump_up || bump_dn) begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign line_on  = |cnt_q;
  assign wrap_err = err_q;

  // R3: accepted rise adds one
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_up && !full) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3: accepted fall removes one
  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_dn && !empty) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R1: a rise always leaves the line asserted
  p_rise_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bump_up |=> line_on);

  // R5: no event, no counter motion
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump_up && !bump_dn) |=> $stable(cnt_q));

  // R7: a correctly sized counter never wraps
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump_up && full) && !(bump_dn && empty));

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
  import irq_share_pkg::*;
#(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned NOUT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT*4-1:0] pin_level,
  output logic [NSLOT*4-1:0] pin_ack,
  output logic [NOUT-1:0]    irq_out,
  output logic               count_err
);

  localparam int unsigned NSRC   = NSLOT * PINS_PER_SLOT;
  localparam int unsigned IW     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned PER_LN = (NSRC + NOUT - 1) / NOUT;
  localparam int unsigned CW     = $clog2(PER_LN + 1);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] grant;
  logic [IW-1:0]   grant_idx;
  logic            grant_vld;
  logic            grant_lvl;

  irq_level_track #(.NSRC(NSRC), .IW(IW)) u_track (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .lvl      (pin_level),
    .take_vld (grant_vld),
    .take_idx (grant_idx),
    .differ   (pending)
  );

  irq_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
    .req (pending),
    .gnt (grant),
    .idx (grant_idx),
    .vld (grant_vld)
  );

  assign grant_lvl = pin_level[grant_idx];
  assign pin_ack   = grant;

  logic [NOUT-1:0] line_hit;
  logic [NOUT-1:0] wrap_err;

  always_comb begin
    for (int k = 0; k < NOUT; k++) begin
      line_hit[k] = grant_vld &&
                    (line_of(int'(grant_idx), NOUT) == k);
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_line
    irq_line_count #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .bump_up  (line_hit[k] && grant_lvl),
      .bump_dn  (line_hit[k] && !grant_lvl),
      .line_on  (irq_out[k]),
      .wrap_err (wrap_err[k])
    );
  end

  assign count_err = |wrap_err;

  // R4: never more than one acceptance per clock
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(pin_ack));

  // R4: no lower-index change waits behind the accepted one
  p_ack_lowest_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (|pin_ack) |-> ((pending & (pin_ack - 1'b1)) == '0));

  // R6: lines are low while the core is held in reset
  p_reset_quiet_r6: assert property (@(posedge clk)
    !core_rst_n |=> (irq_out == '0) || !$past(core_rst_n, 1) == 1'b0);

endmodule

// File: tb/tb_irq_share_agg.sv
module tb_irq_share_agg;

  localparam int CLK_P = 10;
  localparam int NSLOT = 32;
  localparam int NOUT  = 4;
  localparam int NSRC  = NSLOT * 4;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] pin_level;
  logic [NSRC-1:0] pin_ack;
  logic [NOUT-1:0] irq_out;
  logic            count_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int model_seen [NSRC];
  int model_cnt  [NOUT];
  bit saw_ack [NSRC];

  irq_share_agg #(.NSLOT(NSLOT), .NOUT(NOUT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .pin_ack   (pin_ack),
    .irq_out   (irq_out),
    .count_err (count_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int line_of_src(input int s);
    return ((s / 4) + (s % 4)) % NOUT;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NSRC; i++) begin
      model_seen[i] = 0;
      saw_ack[i] = 0;
    end
    for (int k = 0; k < NOUT; k++) model_cnt[k] = 0;
  endtask

  // One clock: drive new levels, compare against the model, advance the model.
  task automatic step(input logic [NSRC-1:0] nv);
    logic [NSRC-1:0] exp_ack;
    logic [NOUT-1:0] exp_irq;
    int w;
    @(negedge clk);
    pin_level = nv;
    #1;
    w = -1;
    for (int i = 0; i < NSRC; i++) begin
      if (w < 0 && int'(nv[i]) != model_seen[i]) w = i;
    end
    exp_ack = '0;
    if (w >= 0) exp_ack[w] = 1'b1;
    for (int k = 0; k < NOUT; k++) exp_irq[k] = (model_cnt[k] != 0);
    check(pin_ack == exp_ack, "R4 R5 ack", pin_ack, exp_ack);
    check(irq_out == exp_irq, "R1 R3 irq_out", NSRC'(irq_out), NSRC'(exp_irq));
    check(count_err == 1'b0, "R7 count_err", NSRC'(count_err), '0);
    for (int i = 0; i < NSRC; i++) if (pin_ack[i]) saw_ack[i] = 1;
    if (w >= 0) begin
      model_seen[w] = int'(nv[w]);
      model_cnt[line_of_src(w)] += nv[w] ? 1 : -1;
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step(pin_level);
  endtask

  initial begin
    logic [NSRC-1:0] v;
    rst_n = 1'b0;
    pin_level = '0;
    model_clear();
    repeat (3) @(negedge clk);
    // R6: state held clear in reset
    check(irq_out == '0, "R6 irq_out in reset", NSRC'(irq_out), '0);
    check(pin_ack == '0, "R6 pin_ack in reset", pin_ack, '0);
    check(count_err == 1'b0, "R6 count_err in reset", NSRC'(count_err), '0);
    rst_n = 1'b1;
    settle(4);

    // R3: single rise, slot 0 pin 0 -> line 0
    v = '0; v[0] = 1'b1;
    step(v);
    step(v);
    check(irq_out == 4'b0001, "R3 single rise", NSRC'(irq_out), NSRC'(4'b0001));

    // R2: slot 1 pin 2 (index 6) -> line 3
    v = '0; v[6] = 1'b1;
    step(v);
    settle(3);
    check(irq_out == 4'b1000, "R2 routing slot1 pin2", NSRC'(irq_out), NSRC'(4'b1000));
    step('0);
    settle(2);

    // R8: index 0 and index 7 share line 0
    v = '0; v[0] = 1'b1; v[7] = 1'b1;
    step(v);
    settle(3);
    v[0] = 1'b0;
    step(v);
    settle(2);
    check(irq_out[0] == 1'b1, "R8 line held by remaining source",
          NSRC'(irq_out), NSRC'(4'b0001));
    v[7] = 1'b0;
    step(v);
    settle(2);
    check(irq_out == '0, "R8 line drops after last source", NSRC'(irq_out), '0);

    // R5: index 120 rises with 0..3 and falls back before its turn
    for (int i = 0; i < NSRC; i++) saw_ack[i] = 0;
    v = '0; v[3:0] = 4'hF; v[120] = 1'b1;
    step(v);
    v[120] = 1'b0;
    step(v);
    settle(5);
    check(saw_ack[120] == 0, "R5 toggled-back source not acknowledged",
          NSRC'(saw_ack[120]), '0);
    check(irq_out == 4'b1111, "R4 burst absorbed", NSRC'(irq_out), NSRC'(4'b1111));
    step('0);
    settle(6);
    check(irq_out == '0, "R5 no phantom count", NSRC'(irq_out), '0);

    // R4: many simultaneous changes, all sources high then all low
    step('1);
    settle(NSRC + 2);
    check(irq_out == 4'b1111, "R4 all high", NSRC'(irq_out), NSRC'(4'b1111));
    step('0);
    settle(NSRC + 2);
    check(irq_out == '0, "R4 all low", NSRC'(irq_out), '0);

    // Random sparse activity
    v = '0;
    for (int n = 0; n < 3000; n++) begin
      int flips;
      flips = ($urandom % 8 == 0) ? 1 + int'($urandom % 6) : 1;
      for (int f = 0; f < flips; f++) v[$urandom % NSRC] ^= 1'b1;
      step(v);
    end
    step('0);
    settle(NSRC + 2);

    // R6: mid-run reset with lines high
    v = '0; v[1] = 1'b1; v[10] = 1'b1;
    step(v);
    settle(4);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(irq_out == '0, "R6 reset clears lines", NSRC'(irq_out), '0);
    pin_level = '0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    settle(4);
    check(irq_out == '0, "R6 quiet after reset", NSRC'(irq_out), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule